// File: doc/BRIEF.md
# Five-Channel Prescaled Interval and PWM Timer

This block is a bank of five down-counting timers driven from one clock. Two shared 8-bit prescalers slow the clock down, one for the low channel pair and one for the upper three channels. Each channel then applies its own power-of-two divider to produce its counting step. Software programs the block through a plain word-addressed register port with write enable, address, write data and a combinational read-data return.

Every channel has a buffered count value. The four lower channels also have a buffered compare value and a PWM pin. Buffered values reach the working counter and compare registers only in two ways: while the channel's update bit is held, or at an auto-reload. Each channel pulses its tick output for one cycle when its count runs out. The fifth channel has no compare and no pin and is used only as an interval timer. The working counter of each channel can be read back at an observation address.

Top module: `pwm_timer_bank`

## Requirements
- R1: After reset every readable address (0 to 31) returns zero, every `pwm_out` bit is low and no `tick` bit pulses.
- R2: The registers return the last word written to them. The addresses are: prescalers at 0, divider selects at 1, control at 2, count buffer of channel c<4 at 3+3c, compare buffer of channel c<4 at 4+3c, and count buffer of channel 4 at 15.
- R3: While a channel's update bit is set, its working counter and compare load from the buffers, whether or not the channel is started. The working counter can be read at 5+3c for c<4 and at 16 for channel 4.
- R4: Writing a count buffer without an update leaves the working counter unchanged.
- R5: One counting step lasts (P+1)·2^d clocks. P is prescaler bits 7:0 for channels 0 and 1 and bits 15:8 for channels 2 to 4. d is divider-select bits [4c+3:4c] of address 1.
- R6: A started channel with auto-reload counts N down to 1 and reloads from the buffers. Its `tick` pulses once per N steps.
- R7: A PWM pin is high while its started working counter is between 1 and the working compare value, inclusive. Per period it is therefore high for min(C,N) steps.
- R8: With auto-reload clear, a started channel pulses `tick` once, stops at zero and holds its pin low.
- R9: Clearing a start bit freezes that channel's working counter and forces its pin low.
- R10: Control bits for channel c<4 are start at 4c, update at 4c+1 and reload at 4c+2. For channel 4 they are start at 16, update at 17 and reload at 20. Channel 4 times and ticks like the others but has no compare and no pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, same cycle |
| pwm_out | output | 4 | PWM pins of channels 0 to 3 |
| tick | output | 5 | One-cycle count-expiry pulse per channel |

## Verification
Faults in the prescaler or divider state change the spacing between two consecutive `tick` pulses, so they show within one full period. A wrong compare load or wrong compare logic changes how many cycles `pwm_out` stays high in that same window. Faults in the working counter's load, freeze or stop behaviour show on the very next read of its observation address. A wrong control bit position shows as a channel that never ticks, or that ticks when it should not, within one period.

// File: rtl/pwm_timer_pkg.sv
`timescale 1ns/1ps
package pwm_timer_pkg;
  localparam int NCH  = 5;   // channels in the bank
  localparam int NPWM = 4;   // channels with compare and pin
  localparam int A_PRESC = 0;
  localparam int A_DSEL  = 1;
  localparam int A_CTRL  = 2;
  localparam int A_BASE  = 3;
  localparam int A_STEP  = 3;
  localparam int A_TMR_CNTB = A_BASE + A_STEP * NPWM;
  localparam int A_TMR_OBS  = A_TMR_CNTB + 1;

  function automatic int cntb_addr(input int c);
    return (c < NPWM) ? A_BASE + A_STEP * c : A_TMR_CNTB;
  endfunction
  function automatic int cmpb_addr(input int c);
    return A_BASE + A_STEP * c + 1;
  endfunction
  function automatic int obs_addr(input int c);
    return (c < NPWM) ? A_BASE + A_STEP * c + 2 : A_TMR_OBS;
  endfunction
  function automatic int start_pos(input int c);
    return (c < NPWM) ? 4 * c : 16;
  endfunction
  function automatic int upd_pos(input int c);
    return (c < NPWM) ? 4 * c + 1 : 17;
  endfunction
  function automatic int rld_pos(input int c);
    return (c < NPWM) ? 4 * c + 2 : 20;
  endfunction
  function automatic int presc_group(input int c);
    return (c < 2) ? 0 : 1;
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
`timescale 1ns/1ps
module pwm_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] limit,
  output logic             pulse
);
  logic [PRE_W-1:0] cnt_q;

  // the terminal count also catches a limit lowered below the count
  assign pulse = (cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (pulse) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwm_divider.sv
`timescale 1ns/1ps
module pwm_divider #(
  parameter int DSEL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pre_pulse,
  input  logic [DSEL_W-1:0] sel,
  output logic              step
);
  localparam int DIV_W = (1 << DSEL_W) - 1;

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] mask;

  assign mask = ~({DIV_W{1'b1}} << sel);
  assign step = pre_pulse && ((cnt_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt_q <= '0;
    else if (pre_pulse) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwm_chan.sv
`timescale 1ns/1ps
module pwm_chan #(
  parameter int CNT_W   = 32,
  parameter bit HAS_CMP = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             start,
  input  logic             upd,
  input  logic             rld,
  input  logic [CNT_W-1:0] cntb,
  input  logic [CNT_W-1:0] cmpb,
  output logic [CNT_W-1:0] cnt,
  output logic             tick,
  output logic             out
);
  logic [CNT_W-1:0] cnt_q;
  logic             tick_q;
  logic             at_one, at_zero, advance, expire;

  assign at_one  = (cnt_q == CNT_W'(1));
  assign at_zero = (cnt_q == '0);
  assign advance = start && step && !upd;
  // the count expires on the step that leaves 1, or on every step at 0 when reloading
  assign expire  = advance && (at_one || (at_zero && rld));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= expire;
      if (upd)                     cnt_q <= cntb;
      else if (expire)             cnt_q <= rld ? cntb : '0;
      else if (advance && !at_zero) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt  = cnt_q;
  assign tick = tick_q;

  generate
    if (HAS_CMP) begin : g_cmp
      logic [CNT_W-1:0] cmp_q;
      always_ff @(posedge clk) begin
        if (!rst_n)                     cmp_q <= '0;
        else if (upd || (expire && rld)) cmp_q <= cmpb;
      end
      assign out = start && !at_zero && (cnt_q <= cmp_q);
    end else begin : g_nocmp
      logic unused_cmp;
      assign unused_cmp = ^cmpb;
      assign out = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/pwm_regs.sv
`timescale 1ns/1ps
module pwm_regs
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PRE_W  = 8,
  parameter int DSEL_W = 4,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wdata,
  input  logic [NCH-1:0][CNT_W-1:0]   cnt_obs,
  output logic [PRE_W-1:0]            presc_lo,
  output logic [PRE_W-1:0]            presc_hi,
  output logic [NCH-1:0][DSEL_W-1:0]  dsel,
  output logic [NCH-1:0]              start,
  output logic [NCH-1:0]              upd,
  output logic [NCH-1:0]              rld,
  output logic [NCH-1:0][CNT_W-1:0]   cntb,
  output logic [NPWM-1:0][CNT_W-1:0]  cmpb,
  output logic [DATA_W-1:0]           rdata
);
  logic [DATA_W-1:0]           presc_q, dsel_q, ctrl_q;
  logic [NCH-1:0][CNT_W-1:0]   cntb_q;
  logic [NPWM-1:0][CNT_W-1:0]  cmpb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc_q <= '0;
      dsel_q  <= '0;
      ctrl_q  <= '0;
      cntb_q  <= '0;
      cmpb_q  <= '0;
    end else if (we) begin
      if (addr == ADDR_W'(A_PRESC)) presc_q <= wdata;
      if (addr == ADDR_W'(A_DSEL))  dsel_q  <= wdata;
      if (addr == ADDR_W'(A_CTRL))  ctrl_q  <= wdata;
      for (int c = 0; c < NCH; c++)
        if (addr == ADDR_W'(cntb_addr(c))) cntb_q[c] <= wdata[CNT_W-1:0];
      for (int c = 0; c < NPWM; c++)
        if (addr == ADDR_W'(cmpb_addr(c))) cmpb_q[c] <= wdata[CNT_W-1:0];
    end
  end

  assign presc_lo = presc_q[PRE_W-1:0];
  assign presc_hi = presc_q[2*PRE_W-1:PRE_W];
  assign cntb     = cntb_q;
  assign cmpb     = cmpb_q;

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_fields
      assign dsel[g]  = dsel_q[DSEL_W*g +: DSEL_W];
      assign start[g] = ctrl_q[start_pos(g)];
      assign upd[g]   = ctrl_q[upd_pos(g)];
      assign rld[g]   = ctrl_q[rld_pos(g)];
    end
  endgenerate

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(A_PRESC)) rdata = presc_q;
    if (addr == ADDR_W'(A_DSEL))  rdata = dsel_q;
    if (addr == ADDR_W'(A_CTRL))  rdata = ctrl_q;
    for (int c = 0; c < NCH; c++) begin
      if (addr == ADDR_W'(cntb_addr(c))) rdata = DATA_W'(cntb_q[c]);
      if (addr == ADDR_W'(obs_addr(c)))  rdata = DATA_W'(cnt_obs[c]);
    end
    for (int c = 0; c < NPWM; c++)
      if (addr == ADDR_W'(cmpb_addr(c))) rdata = DATA_W'(cmpb_q[c]);
  end
endmodule

// File: rtl/pwm_timer_bank.sv
`timescale 1ns/1ps
module pwm_timer_bank
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int PRE_W  = 8,
  parameter int DSEL_W = 4,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [NPWM-1:0]   pwm_out,
  output logic [NCH-1:0]    tick
);
  logic [PRE_W-1:0]            presc_lo, presc_hi;
  logic [NCH-1:0][DSEL_W-1:0]  dsel_w;
  logic [NCH-1:0]              start_w, upd_w, rld_w;
  logic [NCH-1:0][CNT_W-1:0]   cntb_w, cnt_w;
  logic [NPWM-1:0][CNT_W-1:0]  cmpb_w;
  logic [1:0]                  pre_pulse;

  pwm_regs #(
    .CNT_W(CNT_W), .PRE_W(PRE_W), .DSEL_W(DSEL_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .cnt_obs(cnt_w), .presc_lo(presc_lo), .presc_hi(presc_hi), .dsel(dsel_w),
    .start(start_w), .upd(upd_w), .rld(rld_w), .cntb(cntb_w), .cmpb(cmpb_w),
    .rdata(reg_rdata)
  );

  pwm_prescaler #(.PRE_W(PRE_W)) u_pre_lo (
    .clk(clk), .rst_n(rst_n), .limit(presc_lo), .pulse(pre_pulse[0])
  );
  pwm_prescaler #(.PRE_W(PRE_W)) u_pre_hi (
    .clk(clk), .rst_n(rst_n), .limit(presc_hi), .pulse(pre_pulse[1])
  );

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      logic step;
      logic out_c;

      pwm_divider #(.DSEL_W(DSEL_W)) u_div (
        .clk(clk), .rst_n(rst_n), .pre_pulse(pre_pulse[presc_group(g)]),
        .sel(dsel_w[g]), .step(step)
      );

      if (g < NPWM) begin : g_pwm
        pwm_chan #(.CNT_W(CNT_W), .HAS_CMP(1'b1)) u_chan (
          .clk(clk), .rst_n(rst_n), .step(step), .start(start_w[g]),
          .upd(upd_w[g]), .rld(rld_w[g]), .cntb(cntb_w[g]), .cmpb(cmpb_w[g]),
          .cnt(cnt_w[g]), .tick(tick[g]), .out(out_c)
        );
        assign pwm_out[g] = out_c;
      end else begin : g_tmr
        logic unused_out;
        pwm_chan #(.CNT_W(CNT_W), .HAS_CMP(1'b0)) u_chan (
          .clk(clk), .rst_n(rst_n), .step(step), .start(start_w[g]),
          .upd(upd_w[g]), .rld(rld_w[g]), .cntb(cntb_w[g]), .cmpb('0),
          .cnt(cnt_w[g]), .tick(tick[g]), .out(out_c)
        );
        assign unused_out = out_c;
      end
    end
  endgenerate
endmodule

// File: rtl/pwm_timer_bank_chk.sv
`timescale 1ns/1ps
module pwm_timer_bank_chk
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NCH-1:0]            tick,
  input logic [NCH-1:0]            start,
  input logic [NCH-1:0]            upd,
  input logic [NCH-1:0]            rld,
  input logic [NCH-1:0][CNT_W-1:0] cnt,
  input logic [NCH-1:0][CNT_W-1:0] cntb
);
  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_chk
      // R3
      upd_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd[g] |=> cnt[g] == $past(cntb[g]));
      // R9
      stopped_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start[g] && !upd[g]) |=> $stable(cnt[g]));
      // R9
      tick_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick[g] |-> $past(start[g]));
      // R6
      tick_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick[g] |-> ((cnt[g] == '0 && !$past(rld[g])) ||
                     (cnt[g] == $past(cntb[g]) && $past(rld[g]))));
    end
  endgenerate
endmodule

bind pwm_timer_bank pwm_timer_bank_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .start(start_w), .upd(upd_w),
  .rld(rld_w), .cnt(cnt_w), .cntb(cntb_w)
);

// File: tb/pwm_timer_bank_tb.sv
`timescale 1ns/1ps
module pwm_timer_bank_tb;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  pwm_out;
  logic [4:0]  tick;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  pwm_timer_bank u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out), .tick(tick)
  );

  always #(CLK_NS/2) clk = ~clk;

  // register map, taken from R2, R3 and R10
  function automatic int a_cntb(input int c); return c < 4 ? 3 + 3*c : 15; endfunction
  function automatic int a_cmpb(input int c); return 4 + 3*c; endfunction
  function automatic int a_obs(input int c);  return c < 4 ? 5 + 3*c : 16; endfunction
  function automatic int b_start(input int c); return c < 4 ? 4*c : 16; endfunction
  function automatic int b_upd(input int c);   return c < 4 ? 4*c + 1 : 17; endfunction
  function automatic int b_rld(input int c);   return c < 4 ? 4*c + 2 : 20; endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // all tasks start and end one time unit after a rising edge
  task automatic wr(input int a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = 5'(a); reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    reg_addr = 5'(a);
    @(negedge clk); d = reg_rdata;
    @(posedge clk); #1;
  endtask

  task automatic load(input int c);
    wr(2, 32'(1) << b_upd(c));
  endtask

  // watch channel c from one tick to the next
  task automatic measure(input int c, output int iv, output int hi, output int oth);
    int cyc = 0;
    int t1 = -1;
    int t2 = -1;
    hi = 0; oth = 0;
    while (t2 < 0 && cyc < 4000) begin
      @(negedge clk);
      if (tick[c]) begin
        if (t1 < 0) t1 = cyc;
        else        t2 = cyc;
      end
      if (t1 >= 0 && t2 < 0 && c < 4 && pwm_out[c]) hi++;
      for (int j = 0; j < 5; j++) begin
        if (j != c && tick[j]) oth++;
        if (j != c && j < 4 && pwm_out[j]) oth++;
      end
      @(posedge clk); #1;
      cyc++;
    end
    iv = (t2 < 0) ? -1 : t2 - t1;
  endtask

  initial begin
    #(CLK_NS * 190000);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2, v3;
    int iv, hi, oth, nt;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 32; a++) begin
      rd(a, v);
      chk("R1", "reset read", v, 0);
    end
    chk("R1", "pins after reset", pwm_out, 0);
    chk("R1", "ticks after reset", tick, 0);

    // R2 readback (control carries reload bits only, nothing starts)
    wr(0, 32'h0000_3412);
    wr(1, 32'hFEDC_BA98);
    wr(2, 32'h0010_0044);
    for (int c = 0; c < 5; c++) wr(a_cntb(c), 32'h1000 + 32'(c));
    for (int c = 0; c < 4; c++) wr(a_cmpb(c), 32'h2000 + 32'(c));
    rd(0, v); chk("R2", "prescaler word", v, 32'h0000_3412);
    rd(1, v); chk("R2", "divider word", v, 32'hFEDC_BA98);
    rd(2, v); chk("R2", "control word", v, 32'h0010_0044);
    for (int c = 0; c < 5; c++) begin
      rd(a_cntb(c), v); chk("R2", "count buffer", v, 32'h1000 + 32'(c));
    end
    for (int c = 0; c < 4; c++) begin
      rd(a_cmpb(c), v); chk("R2", "compare buffer", v, 32'h2000 + 32'(c));
    end
    // R4 buffers written, no update: working counters stay zero
    for (int c = 0; c < 5; c++) begin
      rd(a_obs(c), v); chk("R4", "counter untouched by buffer write", v, 0);
    end

    // R3 update with start clear, channel 1 and channel 4
    wr(0, 0); wr(1, 0); wr(2, 0);
    load(1); wr(2, 0);
    rd(a_obs(1), v); chk("R3", "ch1 loaded while stopped", v, 32'h1001);
    wr(15, 9);
    load(4); wr(2, 0);
    rd(16, v); chk("R10", "ch4 update at bit 17", v, 9);

    // R7 / R9 run channel 0 long, then stop it
    wr(a_cntb(0), 1000); wr(a_cmpb(0), 2000); load(0);
    wr(2, (32'(1) << b_start(0)) | (32'(1) << b_rld(0)));
    repeat (5) @(posedge clk); #1;
    chk("R7", "ch0 pin high inside compare", pwm_out[0], 1);
    rd(a_obs(0), v);
    chk("R6", "ch0 counting down", (v < 1000 && v > 900) ? 1 : 0, 1);
    wr(2, 32'(1) << b_rld(0));
    chk("R9", "ch0 pin low after stop", pwm_out[0], 0);
    rd(a_obs(0), v2);
    repeat (10) @(posedge clk); #1;
    rd(a_obs(0), v3);
    chk("R9", "ch0 counter frozen", v3, v2);
    wr(a_cntb(0), 5);
    rd(a_obs(0), v);
    chk("R4", "running value kept after buffer write", v, v2);
    wr(2, 0);

    // R8 one-shot on channel 2
    wr(a_cntb(2), 3); wr(a_cmpb(2), 5); load(2);
    wr(2, 32'(1) << b_start(2));
    nt = 0; hi = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (tick[2]) nt++;
      if (pwm_out[2]) hi++;
      @(posedge clk); #1;
    end
    chk("R8", "one-shot tick count", nt, 1);
    chk("R8", "one-shot high cycles", hi, 3);
    chk("R8", "one-shot pin low at end", pwm_out[2], 0);
    rd(a_obs(2), v); chk("R8", "one-shot stops at zero", v, 0);
    wr(2, 0);

    // R5 R6 R7 R10 sweep
    for (int c = 0; c < 5; c++)
      for (int ni = 0; ni < 3; ni++)
        for (int ci = 0; ci < (c < 4 ? 3 : 1); ci++)
          for (int pi = 0; pi < 2; pi++)
            for (int d = 0; d < 3; d++) begin
              int n, cm, pa, pb, scale, ehi;
              n  = (ni == 0) ? 1 : (ni == 1) ? 3 : 5;
              cm = (ci == 0) ? 0 : (ci == 1) ? 2 : n + 1;
              pa = pi * 2;
              pb = (pa + 1) % 3;
              scale = ((c < 2 ? pa : pb) + 1) * (1 << d);
              ehi = (cm < n ? cm : n) * scale;
              wr(0, 32'(pa) | (32'(pb) << 8));
              wr(1, 32'(d) << (4*c));
              wr(a_cntb(c), 32'(n));
              if (c < 4) wr(a_cmpb(c), 32'(cm));
              load(c);
              wr(2, (32'(1) << b_start(c)) | (32'(1) << b_rld(c)));
              measure(c, iv, hi, oth);
              chk(c == 4 ? "R10" : "R5", "tick interval (R6)", iv, n * scale);
              if (c < 4) chk("R7", "high cycles per period", hi, ehi);
              chk("R6", "other channels quiet", oth, 0);
              wr(2, 0);
            end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule